// File: doc/BRIEF.md
# Memory-Mapped Interrupt Collector with Edge Capture

This block gathers up to 64 interrupt request lines into two 32-bit groups, the lower group holding sources 0 to 31 and the upper group sources 32 to 63. It presents them to a single processor as one interrupt request output. Software reaches it through an APB slave port with no wait states. Each source has its own enable bit and a sticky capture flag. A mode input picks what the pending view shows. In level mode it shows the live source level. In capture mode it shows the sticky flag, so a source that only pulses briefly is not lost before software services it.

Software programs the enables, sets the global enable bit, and then, on each interrupt, reads the two pending words. It services the lowest set bit first and repeats until both words read zero. In capture mode it acknowledges a source by writing a zero to that bit of the group's flag word. A 64-slot byte array is also provided, in which software records a source number for each channel. The array has no effect on the interrupt path.

Top module: `apb_irq_ctrl`

## Requirements
- R1: After reset, every enable, flag, control and channel-slot register reads zero, and `irq_o` is low.
- R2: The enable words sit at offset 0x10 (sources 0–31, bit n = source n) and 0x28 (sources 32–63, bit n = source 32+n). They read back the last value written, and they change only when written.
- R3: The pending words at 0x14 (lower group) and 0x2C (upper group) are read-only. A pending bit is never set while its enable bit is clear. In level mode (`pulse_mode_i` = 0), pending is the source level ANDed with the enable.
- R4: A rising edge of a source, sampled on `pclk`, sets that source's flag bit. The flag words are at 0x08 (lower) and 0x20 (upper). The flag stays set after the source falls, in either mode. In capture mode (`pulse_mode_i` = 1), pending is the flag ANDed with the enable.
- R5: A write to a flag word clears each bit written as 0 and leaves each bit written as 1 unchanged. If a rising edge on a source arrives in the same cycle as a clearing write to its bit, the flag ends up set.
- R6: `irq_o` is a register. It is high one cycle after a cycle in which the global enable (bit 31 of the control word at 0x00) is set and any pending bit is set, and low otherwise.
- R7: The channel array covers 0x40–0x7F as 16 words. Slot k lives in the word at 0x40 + 4*(k/4), bits [8*(k%4)+7 : 8*(k%4)]. Every word reads back the last value written.
- R8: An access completes in one access phase (`pready` = 1) and never signals an error (`pslverr` = 0). Reads of any offset not listed here return zero. Writes to such offsets, and to the pending words, change no register.
- R9: The control word stores only bit 31. All its other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and block clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1: no wait states |
| pslverr | output | 1 | Always 0 |
| irq_src_i | input | NUM_SRC | Interrupt source levels, synchronous to `pclk` |
| pulse_mode_i | input | 1 | 1 = pending shows captured flags, 0 = pending shows source levels |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Several properties are checked on every cycle. The interrupt output must follow the gated OR of pending with exactly one cycle of delay. No pending bit may appear without its enable. Enables and flags change only under a write to their own offsets. A sampled rising edge must always leave its flag set, even against a clearing write. Some behaviour only the bench scenarios can show: exact read-back values, level versus capture selection, the zero-returning holes in the map, the single stored control bit, and channel-slot storage. The bench drives random enables, sources, flag clears and mode changes against a shadow model, plus directed cases for the same-cycle edge-versus-clear race and the two-cycle path from source edge to `irq_o`.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Width of one source group and of the bus data path.
  localparam int unsigned GRP_W   = 32;
  // Bit of the control word holding the global enable.
  localparam int unsigned GEN_BIT = 31;

  // Fixed register offsets (byte addresses) that software decodes.
  localparam logic [11:0] OFF_CTRL  = 12'h000;
  localparam logic [11:0] OFF_EN0   = 12'h010;
  localparam logic [11:0] GRP_STEP  = 12'h018;
  localparam logic [11:0] FLAG_GAP  = 12'h008;
  localparam logic [11:0] PEND_GAP  = 12'h004;
  localparam logic [11:0] OFF_MAP   = 12'h040;

  // Enable word of group g; flag word lies FLAG_GAP below, pending PEND_GAP above.
  function automatic logic [11:0] grp_en_off(input int unsigned g);
    return OFF_EN0 + GRP_STEP * 12'(g);
  endfunction

  function automatic logic [11:0] grp_flag_off(input int unsigned g);
    return grp_en_off(g) - FLAG_GAP;
  endfunction

  function automatic logic [11:0] grp_pend_off(input int unsigned g);
    return grp_en_off(g) + PEND_GAP;
  endfunction

endpackage

// File: rtl/irqc_grp.sv
// One 32-source group: enable register, sticky edge flags, pending view.
module irqc_grp #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         pulse_mode,
  input  logic         en_we,
  input  logic         flag_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] pend
);

  logic [W-1:0] src_q;
  logic [W-1:0] rise;
  logic [W-1:0] en_d;
  logic [W-1:0] flag_d;

  always_comb begin
    rise   = src & ~src_q;
    en_d   = en_q;
    flag_d = flag_q;
    if (en_we) begin
      en_d = wdata;
    end
    if (flag_we) begin
      flag_d = flag_q & wdata;
    end
    // A fresh edge always wins over a clearing write.
    flag_d = flag_d | rise;
  end

  always_comb begin
    if (pulse_mode) begin
      pend = flag_q & en_q;
    end else begin
      pend = src & en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      src_q  <= src;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/irqc_chan_map.sv
// Byte-per-channel slot array, four slots packed per word.
module irqc_chan_map #(
  parameter int unsigned WORDS = 16,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word
);

  logic [31:0] word_q [WORDS];
  logic [31:0] word_d [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_comb begin
      word_d[w] = word_q[w];
      if (we && (idx == IDX_W'(w))) begin
        word_d[w] = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else begin
        word_q[w] <= word_d[w];
      end
    end
  end

  assign rd_word = word_q[idx];

endmodule

// File: rtl/irqc_apb_if.sv
// Address decode, write strobes and read multiplexer.
module irqc_apb_if
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_GRP   = 2,
  parameter int unsigned MAP_WORDS = 16,
  localparam int unsigned MAP_IDX_W = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1
) (
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic                 gen_q,
  input  logic [GRP_W-1:0]     en_q   [NUM_GRP],
  input  logic [GRP_W-1:0]     flag_q [NUM_GRP],
  input  logic [GRP_W-1:0]     pend   [NUM_GRP],
  input  logic [31:0]          map_rd,
  output logic                 wr_ctrl,
  output logic [NUM_GRP-1:0]   wr_en,
  output logic [NUM_GRP-1:0]   wr_flag,
  output logic                 wr_map,
  output logic [MAP_IDX_W-1:0] map_idx,
  output logic [31:0]          prdata
);

  logic              wr_cyc;
  logic [ADDR_W-1:0] aw;
  logic [ADDR_W-1:0] map_off;
  logic              map_hit;

  assign wr_cyc  = psel & penable & pwrite;
  assign aw      = {paddr[ADDR_W-1:2], 2'b00};
  assign map_off = aw - ADDR_W'(OFF_MAP);
  assign map_hit = (aw >= ADDR_W'(OFF_MAP)) &&
                   (aw <  ADDR_W'(OFF_MAP) + ADDR_W'(4 * MAP_WORDS));
  assign map_idx = map_off[MAP_IDX_W+1:2];

  always_comb begin
    prdata  = '0;
    wr_ctrl = 1'b0;
    wr_en   = '0;
    wr_flag = '0;
    wr_map  = 1'b0;
    if (aw == ADDR_W'(OFF_CTRL)) begin
      prdata[GEN_BIT] = gen_q;
      wr_ctrl         = wr_cyc;
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (aw == ADDR_W'(grp_en_off(g))) begin
        prdata   = en_q[g];
        wr_en[g] = wr_cyc;
      end
      if (aw == ADDR_W'(grp_flag_off(g))) begin
        prdata     = flag_q[g];
        wr_flag[g] = wr_cyc;
      end
      if (aw == ADDR_W'(grp_pend_off(g))) begin
        prdata = pend[g];
      end
    end
    if (map_hit) begin
      prdata = map_rd;
      wr_map = wr_cyc;
    end
  end

endmodule

// File: rtl/apb_irq_ctrl.sv
// Top: APB interrupt collector with sticky edge capture.
module apb_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               pclk,
  input  logic               presetn,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               pulse_mode_i,
  output logic               irq_o
);

  localparam int unsigned NUM_GRP   = NUM_SRC / GRP_W;
  localparam int unsigned MAP_WORDS = NUM_SRC / 4;
  localparam int unsigned MAP_IDX_W = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_s = rst_pipe[1];

  logic                 wr_ctrl;
  logic [NUM_GRP-1:0]   wr_en;
  logic [NUM_GRP-1:0]   wr_flag;
  logic                 wr_map;
  logic [MAP_IDX_W-1:0] map_idx;
  logic [31:0]          map_rd;

  logic [GRP_W-1:0] en_q   [NUM_GRP];
  logic [GRP_W-1:0] flag_q [NUM_GRP];
  logic [GRP_W-1:0] pend   [NUM_GRP];

  logic [NUM_SRC-1:0] en_all;
  logic [NUM_SRC-1:0] flag_all;
  logic [NUM_SRC-1:0] pend_all;

  // Global enable bit of the control word.
  logic gen_q;
  logic gen_d;

  always_comb begin
    gen_d = gen_q;
    if (wr_ctrl) begin
      gen_d = pwdata[GEN_BIT];
    end
  end

  always_ff @(posedge pclk or negedge rst_s) begin
    if (!rst_s) begin
      gen_q <= 1'b0;
    end else begin
      gen_q <= gen_d;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    irqc_grp #(.W(GRP_W)) u_grp (
      .clk        (pclk),
      .rst_n      (rst_s),
      .src        (irq_src_i[g*GRP_W +: GRP_W]),
      .pulse_mode (pulse_mode_i),
      .en_we      (wr_en[g]),
      .flag_we    (wr_flag[g]),
      .wdata      (pwdata),
      .en_q       (en_q[g]),
      .flag_q     (flag_q[g]),
      .pend       (pend[g])
    );
    assign en_all[g*GRP_W +: GRP_W]   = en_q[g];
    assign flag_all[g*GRP_W +: GRP_W] = flag_q[g];
    assign pend_all[g*GRP_W +: GRP_W] = pend[g];
  end

  irqc_chan_map #(.WORDS(MAP_WORDS)) u_map (
    .clk     (pclk),
    .rst_n   (rst_s),
    .we      (wr_map),
    .idx     (map_idx),
    .wdata   (pwdata),
    .rd_word (map_rd)
  );

  irqc_apb_if #(
    .ADDR_W    (ADDR_W),
    .NUM_GRP   (NUM_GRP),
    .MAP_WORDS (MAP_WORDS)
  ) u_if (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .gen_q   (gen_q),
    .en_q    (en_q),
    .flag_q  (flag_q),
    .pend    (pend),
    .map_rd  (map_rd),
    .wr_ctrl (wr_ctrl),
    .wr_en   (wr_en),
    .wr_flag (wr_flag),
    .wr_map  (wr_map),
    .map_idx (map_idx),
    .prdata  (prdata)
  );

  // Registered request line.
  logic irq_d;
  logic irq_q;

  assign irq_d = gen_q & (|pend_all);

  always_ff @(posedge pclk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o   = irq_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/irqc_chk.sv
// Cycle-by-cycle properties, attached to the top by bind.
module irqc_chk
  import irqc_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic               pready,
  input logic               pslverr,
  input logic               irq_o,
  input logic               gen_q,
  input logic [NUM_SRC-1:0] src_all,
  input logic [NUM_SRC-1:0] en_all,
  input logic [NUM_SRC-1:0] flag_all,
  input logic [NUM_SRC-1:0] pend_all
);

  localparam int unsigned NUM_GRP = NUM_SRC / GRP_W;

  logic              wr_cyc;
  logic [ADDR_W-1:0] aw;
  logic              en_touch;
  logic              flag_touch;
  logic [NUM_SRC-1:0] src_d;
  logic [NUM_SRC-1:0] rise;

  assign wr_cyc = psel & penable & pwrite;
  assign aw     = {paddr[ADDR_W-1:2], 2'b00};

  always_comb begin
    en_touch   = 1'b0;
    flag_touch = 1'b0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (wr_cyc && aw == ADDR_W'(grp_en_off(g)))   en_touch   = 1'b1;
      if (wr_cyc && aw == ADDR_W'(grp_flag_off(g))) flag_touch = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_d <= '0;
    end else begin
      src_d <= src_all;
    end
  end
  assign rise = src_all & ~src_d;

  AST_APB_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr); // R8

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_q && (|pend_all)) |=> irq_o); // R6

  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gen_q && (|pend_all)) |=> !irq_o); // R6

  AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all & ~en_all) == '0); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_touch |=> $stable(en_all)); // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_touch |=> ((flag_all & $past(flag_all)) == $past(flag_all))); // R4

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((flag_all & $past(rise)) == $past(rise))); // R5

endmodule

bind apb_irq_ctrl irqc_chk #(
  .ADDR_W  (ADDR_W),
  .NUM_SRC (NUM_SRC)
) u_irqc_chk (
  .clk      (pclk),
  .rst_n    (rst_s),
  .psel     (psel),
  .penable  (penable),
  .pwrite   (pwrite),
  .paddr    (paddr),
  .pready   (pready),
  .pslverr  (pslverr),
  .irq_o    (irq_o),
  .gen_q    (gen_q),
  .src_all  (irq_src_i),
  .en_all   (en_all),
  .flag_all (flag_all),
  .pend_all (pend_all)
);

// File: tb/tb_apb_irq_ctrl.sv
module tb_apb_irq_ctrl;

  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned NUM_SRC = 64;

  logic               pclk;
  logic               presetn;
  logic               psel;
  logic               penable;
  logic               pwrite;
  logic [ADDR_W-1:0]  paddr;
  logic [31:0]        pwdata;
  logic [31:0]        prdata;
  logic               pready;
  logic               pslverr;
  logic [NUM_SRC-1:0] irq_src_i;
  logic               pulse_mode_i;
  logic               irq_o;

  apb_irq_ctrl #(.ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC)) dut (
    .pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pslverr, .irq_src_i, .pulse_mode_i, .irq_o
  );

  initial pclk = 1'b0;
  always #2 pclk = ~pclk;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  // Shadow model
  logic [63:0] en_m, flag_m, src_m;
  logic        gen_m, mode_m;
  logic [31:0] map_m [16];

  function automatic logic [63:0] pend_exp();
    return (mode_m ? flag_m : src_m) & en_m;
  endfunction

  function automatic logic irq_exp();
    return gen_m && (|pend_exp());
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    d = prdata;
    chk("R8 pready/pslverr", {62'd0, pready, pslverr}, 64'd2);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    chk(req, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge pclk);
    irq_src_i = v;
    flag_m    = flag_m | (v & ~src_m);
    src_m     = v;
  endtask

  task automatic irq_chk(input string req);
    repeat (2) @(posedge pclk);
    #1;
    chk(req, {63'd0, irq_o}, {63'd0, irq_exp()});
  endtask

  task automatic full_chk();
    logic [63:0] p;
    p = pend_exp();
    rd_chk(mode_m ? "R4 pend lo" : "R3 pend lo", 12'h014, p[31:0]);
    rd_chk(mode_m ? "R4 pend hi" : "R3 pend hi", 12'h02C, p[63:32]);
    rd_chk("R4 flag lo", 12'h008, flag_m[31:0]);
    rd_chk("R4 flag hi", 12'h020, flag_m[63:32]);
    rd_chk("R2 en lo", 12'h010, en_m[31:0]);
    rd_chk("R2 en hi", 12'h028, en_m[63:32]);
    irq_chk("R6 irq");
  endtask

  // Watchdog
  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] v;
    int unsigned g;
    void'($urandom(32'h5eed_1234));
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    irq_src_i = '0; pulse_mode_i = 1'b0; presetn = 1'b0;
    en_m = '0; flag_m = '0; src_m = '0; gen_m = 1'b0; mode_m = 1'b0;
    for (int i = 0; i < 16; i++) map_m[i] = '0;
    repeat (3) @(posedge pclk);
    #1;
    chk("R1 irq in reset", {63'd0, irq_o}, 64'd0);
    @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(posedge pclk);

    // R1 reset values
    rd_chk("R1 ctrl", 12'h000, 32'd0);
    rd_chk("R1 en lo", 12'h010, 32'd0);
    rd_chk("R1 en hi", 12'h028, 32'd0);
    rd_chk("R1 flag lo", 12'h008, 32'd0);
    rd_chk("R1 flag hi", 12'h020, 32'd0);
    rd_chk("R1 map0", 12'h040, 32'd0);
    rd_chk("R1 map15", 12'h07C, 32'd0);
    #1 chk("R1 irq", {63'd0, irq_o}, 64'd0);

    // R9 control stores only the top bit
    apb_write(12'h000, 32'hFFFF_FFFF); gen_m = 1'b1;
    rd_chk("R9 ctrl all ones", 12'h000, 32'h8000_0000);
    apb_write(12'h000, 32'h7FFF_FFFF); gen_m = 1'b0;
    rd_chk("R9 ctrl low bits", 12'h000, 32'h0000_0000);

    // R3 level mode directed
    apb_write(12'h010, 32'hF0F0_F0F0); en_m[31:0] = 32'hF0F0_F0F0;
    set_src(64'h0000_0001_FF00_FF00);
    rd_chk("R3 level pend lo", 12'h014, 32'hF000_F000);
    rd_chk("R3 level pend hi (disabled)", 12'h02C, 32'h0);
    set_src(64'h0);
    rd_chk("R3 level follows source", 12'h014, 32'h0);

    // R4 flags remain after sources drop
    rd_chk("R4 flag kept lo", 12'h008, flag_m[31:0]);
    rd_chk("R4 flag kept hi", 12'h020, flag_m[63:32]);

    // R8 writes to pending and holes are ignored, holes read zero
    apb_write(12'h014, 32'hFFFF_FFFF);
    apb_write(12'h030, 32'hFFFF_FFFF);
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_write(12'h800, 32'hFFFF_FFFF);
    rd_chk("R8 hole 0x30", 12'h030, 32'h0);
    rd_chk("R8 hole 0x04", 12'h004, 32'h0);
    rd_chk("R8 hole 0xFFC", 12'hFFC, 32'h0);
    rd_chk("R8 ctrl untouched", 12'h000, 32'h0);
    full_chk();

    // R7 channel array
    for (int w = 0; w < 16; w++) begin
      v = $urandom;
      apb_write(12'h040 + 12'(4 * w), v);
      map_m[w] = v;
    end
    for (int w = 0; w < 16; w++) begin
      rd_chk("R7 map word", 12'h040 + 12'(4 * w), map_m[w]);
    end
    apb_write(12'h044, 32'h0000_2A00); map_m[1] = 32'h0000_2A00;
    apb_read(12'h044, d);
    chk("R7 slot 5 byte", {56'd0, d[15:8]}, 64'h2A);

    // R5 clear and same-cycle edge vs clear
    set_src(64'h0);
    mode_m = 1'b1;
    @(negedge pclk) pulse_mode_i = 1'b1;
    set_src(64'h0000_0000_0000_0030);
    apb_write(12'h008, 32'hFFFF_FFEF); flag_m[4] = 1'b0;
    rd_chk("R5 write 0 clears, 1 keeps", 12'h008, flag_m[31:0]);
    set_src(64'h0);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; paddr = 12'h008; pwdata = 32'h0; penable = 1'b0;
    @(negedge pclk);
    penable = 1'b1;
    irq_src_i = 64'h8;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    flag_m[31:0] = 32'h8; src_m = 64'h8;
    rd_chk("R5 edge wins over clear", 12'h008, 32'h8);

    // R6 latency from edge to irq
    apb_write(12'h008, 32'h0); flag_m[31:0] = '0;
    apb_write(12'h020, 32'h0); flag_m[63:32] = '0;
    set_src(64'h0);
    apb_write(12'h010, 32'h80); en_m[31:0] = 32'h80;
    apb_write(12'h028, 32'h0);  en_m[63:32] = '0;
    apb_write(12'h000, 32'h8000_0000); gen_m = 1'b1;
    irq_chk("R6 idle low");
    @(negedge pclk);
    irq_src_i = 64'h80; flag_m[7] = 1'b1; src_m = 64'h80;
    @(posedge pclk); #1;
    chk("R6 low one edge after source", {63'd0, irq_o}, 64'd0);
    @(posedge pclk); #1;
    chk("R6 high two edges after source", {63'd0, irq_o}, 64'd1);
    set_src(64'h0);
    irq_chk("R4 pulse held");
    apb_write(12'h000, 32'h0); gen_m = 1'b0;
    irq_chk("R6 global disable");
    apb_write(12'h000, 32'h8000_0000); gen_m = 1'b1;
    apb_write(12'h008, 32'h0); flag_m[31:0] = '0;
    irq_chk("R5 ack drops irq");

    // Random phase
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 6))
        0: begin
          g = $urandom_range(0, 1);
          v = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
          apb_write(g ? 12'h028 : 12'h010, v);
          en_m[g*32 +: 32] = v;
        end
        1: set_src({$urandom, $urandom} & {$urandom, $urandom});
        2: begin
          g = $urandom_range(0, 1);
          v = $urandom | $urandom;
          apb_write(g ? 12'h020 : 12'h008, v);
          flag_m[g*32 +: 32] = flag_m[g*32 +: 32] & v;
        end
        3: begin
          v = $urandom;
          apb_write(12'h000, v);
          gen_m = v[31];
        end
        4: begin
          @(negedge pclk);
          pulse_mode_i = ~pulse_mode_i;
          mode_m = pulse_mode_i;
        end
        default: full_chk();
      endcase
    end
    full_chk();

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule